// File: doc/BRIEF.md
# Output Compare Waveform Channel

This block is a single compare channel built around a prescaled up-counter that wraps at a reload value. Each time the counter steps onto the channel's compare value, that is a match. A two-state reference machine then reacts to the match according to a mode code. The reference can be set, cleared or inverted on a match, or left alone so that the channel serves only as a time base. Two forced modes drive the reference regardless of the counter. The pin level is derived from the reference through a polarity bit and a channel enable bit.

A match sets a sticky flag, which is cleared by a write-one strobe. It also raises one-cycle interrupt and DMA request strobes when they are enabled. The compare value can be written straight into the active register. It can also be held in a buffer that is copied to the active register when the counter wraps (the update event). This allows the compare point to be changed without glitches in the middle of a period.

The reference machine has two states. REF_LOW goes to REF_HIGH on a match in set or toggle mode, or at once in forced-high mode. REF_HIGH goes to REF_LOW on a match in clear or toggle mode, or at once in forced-low mode. In every other case the machine stays in its state.

Top module: `ocw_channel`

## Requirements
- R1: Reset values: counter 0, active compare value 0, reference 0, flag 0, interrupt and DMA strobes 0.
- R2: While `cnt_en` is 1, the counter advances once every `psc`+1 clock cycles. While `cnt_en` is 0, the counter holds its value.
- R3: A tick taken while the counter equals `arr` returns the counter to 0. This is the update event.
- R4: A match is the first cycle in which the counter, having just advanced, equals the active compare value. On the following clock edge `flag_o` becomes 1 and stays 1 until a `flag_clr` pulse clears it. When a clear and a match fall in the same cycle, the match wins.
- R5: Mode code 0 (timing) and the unused codes 6 and 7 leave the reference unchanged, including on a match.
- R6: Mode code 1 drives the reference to 1 on the edge after a match.
- R7: Mode code 2 drives the reference to 0 on the edge after a match.
- R8: Mode code 3 inverts the reference on the edge after every match.
- R9: Mode code 4 forces the reference to 0 and code 5 forces it to 1 on the next edge, whatever the counter is doing.
- R10: `pin_o` equals the reference XOR `polarity` when `chan_en` is 1, and equals `polarity` when `chan_en` is 0.
- R11: With `preload_en` at 0, a `ccr_wr` pulse loads `ccr_wdata` into the active compare value on the next edge.
- R12: With `preload_en` at 1, a write goes only to the buffer, and the buffer is copied to the active value at the update event. If a write and an update event fall in the same cycle, the newly written data becomes active.
- R13: On the edge that sets the flag, `irq_o` pulses high for one cycle if `irq_en` is 1, and `dma_o` pulses high for one cycle if `dma_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter run enable |
| psc | input | PSC_W | Prescaler divide value minus one |
| arr | input | CNT_W | Reload (wrap) value |
| mode | input | 3 | Reference mode code (0..7) |
| polarity | input | 1 | 1 inverts the pin relative to the reference |
| chan_en | input | 1 | Channel output enable |
| preload_en | input | 1 | Buffer compare writes until the update event |
| ccr_wr | input | 1 | Compare value write strobe |
| ccr_wdata | input | CNT_W | Compare value write data |
| flag_clr | input | 1 | Write-one clear of the match flag |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable |
| cnt_o | output | CNT_W | Counter value |
| ccr_o | output | CNT_W | Active compare value |
| ref_o | output | 1 | Reference signal |
| pin_o | output | 1 | Pin level |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request strobe |
| dma_o | output | 1 | DMA request strobe |

## Verification
The two functions that can coincide are the software clear of the flag and a hardware match. The bench waits until the counter port shows the compare value, and pulses `flag_clr` in that same cycle. It then expects the flag to read 1 on the following cycle. A second coincidence is a buffered compare write issued in the cycle when the counter sits at the reload value. The new data must then appear as the active compare value right as the counter reads 0.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
    typedef enum logic [2:0] {
        OCM_TIMING   = 3'd0,
        OCM_SET      = 3'd1,
        OCM_CLEAR    = 3'd2,
        OCM_TOGGLE   = 3'd3,
        OCM_FORCE_LO = 3'd4,
        OCM_FORCE_HI = 3'd5,
        OCM_RSV6     = 3'd6,
        OCM_RSV7     = 3'd7
    } oc_mode_t;

    typedef enum logic {
        REF_LOW  = 1'b0,
        REF_HIGH = 1'b1
    } ref_state_t;
endpackage

// File: rtl/ocw_timebase.sv
module ocw_timebase #(
    parameter int CNT_W = 8,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] arr,
    output logic [CNT_W-1:0] cnt,
    output logic             tick,
    output logic             upd
);
    logic [PSC_W-1:0] pcnt;

    assign tick = cnt_en && (pcnt >= psc);
    assign upd  = tick && (cnt >= arr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
            cnt  <= '0;
        end else if (cnt_en) begin
            if (tick) begin
                pcnt <= '0;
                cnt  <= (cnt >= arr) ? '0 : cnt + 1'b1;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    // R2
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt));
    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (cnt == '0));
endmodule

// File: rtl/ocw_compare.sv
module ocw_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             upd,
    input  logic [CNT_W-1:0] cnt,
    input  logic             preload_en,
    input  logic             ccr_wr,
    input  logic [CNT_W-1:0] ccr_wdata,
    output logic [CNT_W-1:0] ccr_act,
    output logic             match
);
    logic [CNT_W-1:0] ccr_buf;
    logic             stepped;

    assign match = stepped && (cnt == ccr_act);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stepped <= 1'b0;
            ccr_buf <= '0;
            ccr_act <= '0;
        end else begin
            stepped <= tick;
            if (ccr_wr) begin
                ccr_buf <= ccr_wdata;
            end
            if (!preload_en) begin
                if (ccr_wr) begin
                    ccr_act <= ccr_wdata;
                end
            end else if (upd) begin
                ccr_act <= ccr_wr ? ccr_wdata : ccr_buf;
            end
        end
    end

    // R11
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_wr && !preload_en) |=> (ccr_act == $past(ccr_wdata)));
    // R12
    buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !upd) |=> $stable(ccr_act));
endmodule

// File: rtl/ocw_refgen.sv
module ocw_refgen
    import ocw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       match,
    input  logic       polarity,
    input  logic       chan_en,
    output logic       ref_o,
    output logic       pin_o
);
    oc_mode_t   m;
    ref_state_t state, state_nxt;

    assign m = oc_mode_t'(mode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= REF_LOW;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            REF_LOW: begin
                if (m == OCM_FORCE_HI ||
                    (match && (m == OCM_SET || m == OCM_TOGGLE))) begin
                    state_nxt = REF_HIGH;
                end
            end
            REF_HIGH: begin
                if (m == OCM_FORCE_LO ||
                    (match && (m == OCM_CLEAR || m == OCM_TOGGLE))) begin
                    state_nxt = REF_LOW;
                end
            end
            default: state_nxt = REF_LOW;
        endcase
    end

    always_comb begin
        ref_o = (state == REF_HIGH);
        pin_o = chan_en ? (ref_o ^ polarity) : polarity;
    end

    // R5
    timing_keeps_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m == OCM_TIMING || m == OCM_RSV6 || m == OCM_RSV7) |=> $stable(ref_o));
    // R8
    toggle_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m == OCM_TOGGLE && match) |=> (ref_o != $past(ref_o)));
    // R9
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m == OCM_FORCE_HI) |=> ref_o);
    // R9
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m == OCM_FORCE_LO) |=> !ref_o);
endmodule

// File: rtl/ocw_events.sv
module ocw_events (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic flag_clr,
    input  logic irq_en,
    input  logic dma_en,
    output logic flag_o,
    output logic irq_o,
    output logic dma_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            irq_o  <= 1'b0;
            dma_o  <= 1'b0;
        end else begin
            if (match) begin
                flag_o <= 1'b1;
            end else if (flag_clr) begin
                flag_o <= 1'b0;
            end
            irq_o <= match && irq_en;
            dma_o <= match && dma_en;
        end
    end

    // R4
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_o);
    // R13
    strobe_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || dma_o) |-> flag_o);
endmodule

// File: rtl/ocw_channel.sv
module ocw_channel #(
    parameter int CNT_W = 8,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] arr,
    input  logic [2:0]       mode,
    input  logic             polarity,
    input  logic             chan_en,
    input  logic             preload_en,
    input  logic             ccr_wr,
    input  logic [CNT_W-1:0] ccr_wdata,
    input  logic             flag_clr,
    input  logic             irq_en,
    input  logic             dma_en,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] ccr_o,
    output logic             ref_o,
    output logic             pin_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             dma_o
);
    logic tick, upd, match;

    ocw_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .psc(psc), .arr(arr),
        .cnt(cnt_o), .tick(tick), .upd(upd)
    );

    ocw_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .upd(upd), .cnt(cnt_o),
        .preload_en(preload_en), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
        .ccr_act(ccr_o), .match(match)
    );

    ocw_refgen u_ref (
        .clk(clk), .rst_n(rst_n), .mode(mode), .match(match),
        .polarity(polarity), .chan_en(chan_en), .ref_o(ref_o), .pin_o(pin_o)
    );

    ocw_events u_ev (
        .clk(clk), .rst_n(rst_n), .match(match), .flag_clr(flag_clr),
        .irq_en(irq_en), .dma_en(dma_en),
        .flag_o(flag_o), .irq_o(irq_o), .dma_o(dma_o)
    );
endmodule

// File: tb/sim_ocw_channel.sv
module sim_ocw_channel;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic cnt_en, polarity, chan_en, preload_en, ccr_wr, flag_clr, irq_en, dma_en;
    logic [PW-1:0] psc;
    logic [CW-1:0] arr, ccr_wdata;
    logic [2:0] mode;
    logic [CW-1:0] cnt_o, ccr_o;
    logic ref_o, pin_o, flag_o, irq_o, dma_o;
    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocw_channel #(.CNT_W(CW), .PSC_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .psc(psc), .arr(arr),
        .mode(mode), .polarity(polarity), .chan_en(chan_en),
        .preload_en(preload_en), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
        .flag_clr(flag_clr), .irq_en(irq_en), .dma_en(dma_en),
        .cnt_o(cnt_o), .ccr_o(ccr_o), .ref_o(ref_o), .pin_o(pin_o),
        .flag_o(flag_o), .irq_o(irq_o), .dma_o(dma_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cnt_en = 1'b0; psc = '0; arr = 8'd9; mode = 3'd0;
        polarity = 1'b0; chan_en = 1'b1; preload_en = 1'b0; ccr_wr = 1'b0;
        ccr_wdata = '0; flag_clr = 1'b0; irq_en = 1'b0; dma_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_ccr(input logic [CW-1:0] v);
        ccr_wr = 1'b1; ccr_wdata = v;
        @(negedge clk);
        ccr_wr = 1'b0;
    endtask

    task automatic wait_cnt(input logic [CW-1:0] v);
        for (int i = 0; i < 2000 && cnt_o != v; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cnt", cnt_o, 0); chk("R1 ccr", ccr_o, 0); chk("R1 ref", ref_o, 0);
        chk("R1 flag", flag_o, 0); chk("R1 irq", irq_o, 0); chk("R1 dma", dma_o, 0);
    endtask

    task automatic t_prescale();
        int gap;
        logic [CW-1:0] last;
        do_reset();
        psc = 8'd2; arr = 8'd50; cnt_en = 1'b1;
        wait_cnt(8'd2);
        last = cnt_o; gap = 0;
        while (cnt_o == last && gap < 100) begin
            @(negedge clk); gap++;
        end
        chk("R2 prescale gap", gap, 3);
        cnt_en = 1'b0;
        last = cnt_o;
        repeat (6) @(negedge clk);
        chk("R2 hold when stopped", cnt_o, last);
    endtask

    task automatic t_wrap();
        do_reset();
        arr = 8'd5; cnt_en = 1'b1;
        wait_cnt(8'd5);
        @(negedge clk);
        chk("R3 wrap", cnt_o, 0);
    endtask

    task automatic t_set_clear();
        do_reset();
        mode = 3'd1; write_ccr(8'd3); cnt_en = 1'b1;
        wait_cnt(8'd3);
        chk("R6 ref before match", ref_o, 0);
        @(negedge clk);
        chk("R6 set on match", ref_o, 1);
        chk("R10 pin follows", pin_o, 1);
        chk("R4 flag set", flag_o, 1);
        mode = 3'd2;
        wait_cnt(8'd2);
        chk("R7 ref held before match", ref_o, 1);
        wait_cnt(8'd3);
        @(negedge clk);
        chk("R7 clear on match", ref_o, 0);
    endtask

    task automatic t_toggle();
        do_reset();
        mode = 3'd3; arr = 8'd4; write_ccr(8'd2); cnt_en = 1'b1;
        wait_cnt(8'd2);
        @(negedge clk);
        chk("R8 first toggle", ref_o, 1);
        wait_cnt(8'd2);
        @(negedge clk);
        chk("R8 second toggle", ref_o, 0);
    endtask

    task automatic t_timing();
        do_reset();
        mode = 3'd5; @(negedge clk); @(negedge clk);
        mode = 3'd0; write_ccr(8'd4); cnt_en = 1'b1;
        wait_cnt(8'd4);
        @(negedge clk);
        chk("R5 timing ref kept", ref_o, 1);
        chk("R5 timing flag", flag_o, 1);
        mode = 3'd6;
        wait_cnt(8'd4);
        @(negedge clk);
        chk("R5 code 6 ref kept", ref_o, 1);
    endtask

    task automatic t_forced();
        do_reset();
        write_ccr(8'd7);
        mode = 3'd5; @(negedge clk);
        chk("R9 force high", ref_o, 1);
        mode = 3'd4; @(negedge clk);
        chk("R9 force low", ref_o, 0);
        chk("R9 counter idle", cnt_o, 0);
    endtask

    task automatic t_pin();
        do_reset();
        chan_en = 1'b0; polarity = 1'b1; #1;
        chk("R10 disabled pol1", pin_o, 1);
        polarity = 1'b0; #1;
        chk("R10 disabled pol0", pin_o, 0);
        chan_en = 1'b1; polarity = 1'b1; #1;
        chk("R10 inverted ref0", pin_o, 1);
        mode = 3'd5; @(negedge clk);
        chk("R10 inverted ref1", pin_o, 0);
        chan_en = 1'b0; #1;
        chk("R10 disabled ref1", pin_o, 1);
    endtask

    task automatic t_flag();
        do_reset();
        irq_en = 1'b1; dma_en = 1'b0; write_ccr(8'd3); cnt_en = 1'b1;
        wait_cnt(8'd3);
        @(negedge clk);
        chk("R13 irq strobe", irq_o, 1);
        chk("R13 dma gated", dma_o, 0);
        @(negedge clk);
        chk("R13 irq one cycle", irq_o, 0);
        chk("R4 flag sticky", flag_o, 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R4 flag cleared", flag_o, 0);
        dma_en = 1'b1;
        wait_cnt(8'd3);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R4 set wins over clear", flag_o, 1);
        chk("R13 dma strobe", dma_o, 1);
    endtask

    task automatic t_preload();
        do_reset();
        write_ccr(8'd4);
        chk("R11 direct write", ccr_o, 4);
        preload_en = 1'b1; arr = 8'd6; cnt_en = 1'b1;
        wait_cnt(8'd2);
        write_ccr(8'd5);
        chk("R12 buffered not yet active", ccr_o, 4);
        wait_cnt(8'd0);
        chk("R12 transfer at update", ccr_o, 5);
        wait_cnt(8'd6);
        ccr_wr = 1'b1; ccr_wdata = 8'd1;
        @(negedge clk);
        ccr_wr = 1'b0;
        chk("R12 wrap at update", cnt_o, 0);
        chk("R12 write on update wins", ccr_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        t_reset();
        t_prescale();
        t_wrap();
        t_set_clear();
        t_toggle();
        t_timing();
        t_forced();
        t_pin();
        t_flag();
        t_preload();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule